// File: doc/BRIEF.md
# Address Translation Sequencer with Fault Encoder

This block steers a single 32-bit address translation from request to result. A request carries an effective address, an access kind (instruction fetch, load or store), a privilege flag and a real-mode flag. The block first handles real mode. Otherwise it asks an external block-range matcher for a hit. On a miss it selects one of sixteen segment descriptors by the top four address bits and checks for a direct-store segment or a no-execute violation. It then asks an external page-table walker and applies the page protection rules. Direct-store segments take their own path, steered by an instruction-class input.

Every request ends in a one-cycle `done` pulse. The pulse carries either a physical address with permission bits, or an exception kind with an error code. Data-side faults also update a held fault-address register and a held data-status register. The matcher and walker are outside this block. They answer through start/done handshakes and may take any number of cycles.

Top module: `xlate_seq`

## Requirements
- R1: A request is taken only while `req_ready` is 1. Each accepted request gives exactly one `done` pulse of one cycle. `req_valid` raised while busy is ignored.
- R2: When `req_real` is 1, the result is ok with `pa` equal to the effective address and `prot` = 3'b111. Neither `bm_start` nor `pt_start` is pulsed.
- R3: The matcher is consulted first on every request that is not real-mode. On a hit whose `bm_prot` permits the access, the result is `bm_pa` with `prot` = `bm_prot` and no walk is started. On a hit that does not permit the access, the protection fault of R8 is raised. `prot` bit 0 is read, bit 1 is write and bit 2 is execute. A fetch needs execute, a store needs write, and a load (access codes 1 and 3) needs read. Fetch is code 0 and store is code 2.
- R4: After a matcher miss, the segment descriptor is `seg_regs[32*i +: 32]` with i = ea[31:28]. Its fields are: bit 31 direct-store, bit 30 supervisor key, bit 29 user key, bit 28 no-execute, bits 27:0 segment id. When a walk is started, `pt_vsid` carries bits 27:0 and `pt_pidx` carries ea[27:12].
- R5: A fetch from a no-execute segment, or any fetch from a direct-store segment, raises an instruction fault (`exc` = 1) with `err_code` 0x10000000. No walk is started.
- R6: A walk miss raises an instruction fault with code 0x40000000 on a fetch. On a data access it raises a data fault (`exc` = 2) with status 0x40000000 for a load and 0x42000000 for a store.
- R7: The key is the user key when `req_user` = 1 and the supervisor key otherwise. With key 0, pp 0–2 grant read/write and pp 3 grants read. With key 1, pp 0 grants nothing, pp 1 and pp 3 grant read, and pp 2 grants read/write. Execute is granted with read unless the segment is no-execute. A permitted walk hit gives `pa` = {`pt_rpn`, ea[11:0]}.
- R8: A protection violation raises an instruction fault with code 0x08000000 on a fetch. On a data access it raises a data fault with status 0x08000000 for a load and 0x0A000000 for a store.
- R9: A direct-store integer access (class 0, or classes 5–7) is granted read/write when the key is 1 and read only otherwise, with `pa` = ea. A store without write raises R8's fault.
- R10: A direct-store floating-point access (class 1) raises an alignment fault (`exc` = 3) with `err_code` 0. It updates `dar` and leaves `dsisr` unchanged.
- R11: A direct-store reservation access (class 2) gives a data fault with status 0x04000000 for a load and 0x06000000 for a store. An external-control access (class 4) gives 0x04100000 for a load and 0x06100000 for a store.
- R12: A direct-store cache-management access (class 3) completes ok with `pa` = ea and `prot` = 0.
- R13: Every data-side fault loads `dar` with the effective address and reports `err_code` 0. Instruction faults and ok results leave `dar` and `dsisr` unchanged. A faulting result reports `pa` = 0 and `prot` = 0. Both registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| req_user | input | 1 | 1 for user privilege |
| req_real | input | 1 | 1 when translation is off |
| req_dscls | input | 3 | Instruction class for direct-store segments |
| seg_regs | input | 512 | Sixteen packed segment descriptors |
| bm_start | output | 1 | One-cycle start to the block-range matcher |
| bm_ea | output | 32 | Address under translation |
| bm_fetch | output | 1 | Request is an instruction fetch |
| bm_user | output | 1 | Request privilege |
| bm_done | input | 1 | Matcher response strobe |
| bm_hit | input | 1 | Matcher found a range |
| bm_pa | input | 32 | Physical address from the matcher |
| bm_prot | input | 3 | Permission bits from the matcher |
| pt_start | output | 1 | One-cycle start to the page-table walker |
| pt_vsid | output | 28 | Segment id for the walk |
| pt_pidx | output | 16 | Page index within the segment |
| pt_done | input | 1 | Walker response strobe |
| pt_hit | input | 1 | Walker found an entry |
| pt_pp | input | 2 | Entry protection field |
| pt_rpn | input | 20 | Entry physical page number |
| done | output | 1 | One-cycle result strobe |
| ok | output | 1 | Translation granted |
| pa | output | 32 | Physical address |
| prot | output | 3 | Granted permissions {x,w,r} |
| exc | output | 2 | 0 none, 1 instruction, 2 data, 3 alignment |
| err_code | output | 32 | Instruction-fault code, 0 otherwise |
| dar | output | 32 | Held data-fault address |
| dsisr | output | 32 | Held data-fault status word |

## Verification
The bench goes after the priority boundaries. One case is a matcher hit that forbids the access, which a design that fell through to the walk would turn into a miss code. Another is a fetch into a direct-store segment, which a design that tested the instruction class first would report as an alignment or cache result. A third is a no-execute segment on a load, which must still walk. Store/load pairs on every data fault catch a swapped status word. Instruction faults after a data fault catch a design that clobbers `dar` or `dsisr`. A request raised while busy catches a sequencer that restarts mid-walk.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int XLEN    = 32;
  localparam int PG_BITS = 12;
  localparam int SR_T    = 31;
  localparam int SR_KS   = 30;
  localparam int SR_KP   = 29;
  localparam int SR_NX   = 28;

  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2, ACC_LOAD2 = 2'd3} acc_e;
  typedef enum logic [1:0] {EXC_NONE = 2'd0, EXC_INST = 2'd1, EXC_DATA = 2'd2, EXC_ALIGN = 2'd3} exc_e;
  typedef enum logic [2:0] {DS_INT = 3'd0, DS_FLOAT = 3'd1, DS_RESV = 3'd2, DS_CACHE = 3'd3, DS_EXT = 3'd4} dscls_e;
  typedef enum logic [2:0] {FC_NONE, FC_NOEXEC, FC_MISS, FC_PROT, FC_ALIGN, FC_RESV, FC_EXTCTL} fcause_e;

  // prot = {x, w, r}
  function automatic logic acc_permitted(input logic [2:0] p, input logic [1:0] acc);
    case (acc)
      ACC_FETCH: acc_permitted = p[2];
      ACC_STORE: acc_permitted = p[1];
      default:   acc_permitted = p[0];
    endcase
  endfunction
endpackage

// File: rtl/xs_seg_sel.sv
module xs_seg_sel #(
  parameter int XLEN = 32,
  parameter int SEGS = 16,
  localparam int SEL_W  = $clog2(SEGS),
  localparam int VSID_W = XLEN - 4
) (
  input  logic [SEGS*XLEN-1:0] seg_regs,
  input  logic [XLEN-1:0]      ea,
  input  logic                 user,
  output logic                 dstore,
  output logic                 noexec,
  output logic                 key,
  output logic [VSID_W-1:0]    vsid
);
  logic [SEL_W-1:0] idx;
  logic [XLEN-1:0]  sr;

  assign idx    = ea[XLEN-1 -: SEL_W];
  assign sr     = seg_regs[idx*XLEN +: XLEN];
  assign dstore = sr[XLEN-1];
  assign key    = user ? sr[XLEN-3] : sr[XLEN-2];
  assign noexec = sr[XLEN-4];
  assign vsid   = sr[VSID_W-1:0];
endmodule

// File: rtl/xs_prot_eval.sv
module xs_prot_eval (
  input  logic       key,
  input  logic [1:0] pp,
  input  logic       noexec,
  output logic [2:0] prot
);
  logic rd, wr;

  always_comb begin
    if (!key) begin
      rd = 1'b1;
      wr = (pp != 2'd3);
    end else begin
      rd = (pp != 2'd0);
      wr = (pp == 2'd2);
    end
    prot = {rd & ~noexec, wr, rd};
  end
endmodule

// File: rtl/xs_fault_enc.sv
module xs_fault_enc
  import xs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  fcause_e         cause,
  input  logic [1:0]      acc,
  output exc_e            exc,
  output logic [XLEN-1:0] err_code,
  output logic [XLEN-1:0] dstat,
  output logic            dar_we,
  output logic            dstat_we
);
  localparam logic [XLEN-1:0] C_NOEXEC = XLEN'(32'h1000_0000);
  localparam logic [XLEN-1:0] C_MISS   = XLEN'(32'h4000_0000);
  localparam logic [XLEN-1:0] C_PROT   = XLEN'(32'h0800_0000);
  localparam logic [XLEN-1:0] C_RESV   = XLEN'(32'h0400_0000);
  localparam logic [XLEN-1:0] C_EXTC   = XLEN'(32'h0410_0000);
  localparam logic [XLEN-1:0] C_STORE  = XLEN'(32'h0200_0000);

  logic is_fetch, is_store;
  assign is_fetch = (acc == ACC_FETCH);
  assign is_store = (acc == ACC_STORE);

  always_comb begin
    exc      = EXC_NONE;
    err_code = '0;
    dstat    = '0;
    dar_we   = 1'b0;
    dstat_we = 1'b0;
    unique case (cause)
      FC_NONE: ;
      FC_ALIGN: begin
        exc    = EXC_ALIGN;
        dar_we = 1'b1;
      end
      FC_NOEXEC: begin
        exc      = EXC_INST;
        err_code = C_NOEXEC;
      end
      default: begin
        if (is_fetch && (cause == FC_MISS || cause == FC_PROT)) begin
          exc      = EXC_INST;
          err_code = (cause == FC_MISS) ? C_MISS : C_PROT;
        end else begin
          exc      = EXC_DATA;
          dar_we   = 1'b1;
          dstat_we = 1'b1;
          case (cause)
            FC_MISS:  dstat = C_MISS;
            FC_PROT:  dstat = C_PROT;
            FC_RESV:  dstat = C_RESV;
            default:  dstat = C_EXTC;
          endcase
          if (is_store) dstat = dstat | C_STORE;
        end
      end
    endcase
  end
endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
  import xs_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int SEGS    = 16,
  parameter int PG_BITS = 12,
  localparam int VSID_W = XLEN - 4,
  localparam int SEL_W  = $clog2(SEGS),
  localparam int PIDX_W = XLEN - SEL_W - PG_BITS,
  localparam int RPN_W  = XLEN - PG_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [XLEN-1:0]      req_ea,
  input  logic [1:0]           req_acc,
  input  logic                 req_user,
  input  logic                 req_real,
  input  logic [2:0]           req_dscls,
  input  logic [SEGS*XLEN-1:0] seg_regs,
  output logic                 bm_start,
  output logic [XLEN-1:0]      bm_ea,
  output logic                 bm_fetch,
  output logic                 bm_user,
  input  logic                 bm_done,
  input  logic                 bm_hit,
  input  logic [XLEN-1:0]      bm_pa,
  input  logic [2:0]           bm_prot,
  output logic                 pt_start,
  output logic [VSID_W-1:0]    pt_vsid,
  output logic [PIDX_W-1:0]    pt_pidx,
  input  logic                 pt_done,
  input  logic                 pt_hit,
  input  logic [1:0]           pt_pp,
  input  logic [RPN_W-1:0]     pt_rpn,
  output logic                 done,
  output logic                 ok,
  output logic [XLEN-1:0]      pa,
  output logic [2:0]           prot,
  output logic [1:0]           exc,
  output logic [XLEN-1:0]      err_code,
  output logic [XLEN-1:0]      dar,
  output logic [XLEN-1:0]      dsisr
);
  typedef enum logic [2:0] {ST_IDLE, ST_ROUTE, ST_BLK, ST_SEG, ST_WALK} st_e;

  st_e             state;
  logic [XLEN-1:0] ea_q;
  logic [1:0]      acc_q;
  logic            user_q, real_q;
  logic [2:0]      cls_q;

  logic              s_ds, s_nx, s_key;
  logic [VSID_W-1:0] s_vsid;
  logic [2:0]        pg_prot;

  logic              fin, r_ok;
  logic [XLEN-1:0]   r_pa;
  logic [2:0]        r_prot;
  fcause_e           r_cause;
  exc_e              e_exc;
  logic [XLEN-1:0]   e_err, e_dstat;
  logic              e_dar_we, e_dstat_we;
  logic              is_fetch;

  xs_seg_sel #(.XLEN(XLEN), .SEGS(SEGS)) i_seg (
    .seg_regs(seg_regs), .ea(ea_q), .user(user_q),
    .dstore(s_ds), .noexec(s_nx), .key(s_key), .vsid(s_vsid)
  );

  xs_prot_eval i_prot (
    .key(s_key), .pp(pt_pp), .noexec(s_nx), .prot(pg_prot)
  );

  xs_fault_enc #(.XLEN(XLEN)) i_enc (
    .cause(r_cause), .acc(acc_q), .exc(e_exc), .err_code(e_err),
    .dstat(e_dstat), .dar_we(e_dar_we), .dstat_we(e_dstat_we)
  );

  assign req_ready = (state == ST_IDLE);
  assign bm_ea     = ea_q;
  assign bm_fetch  = (acc_q == ACC_FETCH);
  assign bm_user   = user_q;
  assign is_fetch  = (acc_q == ACC_FETCH);

  // Result selection for the step the sequencer is in
  always_comb begin
    fin     = 1'b0;
    r_ok    = 1'b0;
    r_pa    = '0;
    r_prot  = '0;
    r_cause = FC_NONE;
    case (state)
      ST_ROUTE: if (real_q) begin
        fin = 1'b1; r_ok = 1'b1; r_pa = ea_q; r_prot = 3'b111;
      end
      ST_BLK: if (bm_done && bm_hit) begin
        fin = 1'b1;
        if (acc_permitted(bm_prot, acc_q)) begin
          r_ok = 1'b1; r_pa = bm_pa; r_prot = bm_prot;
        end else begin
          r_cause = FC_PROT;
        end
      end
      ST_SEG: begin
        if (s_ds) begin
          fin = 1'b1;
          if (is_fetch) r_cause = FC_NOEXEC;
          else begin
            case (cls_q)
              DS_FLOAT: r_cause = FC_ALIGN;
              DS_RESV:  r_cause = FC_RESV;
              DS_EXT:   r_cause = FC_EXTCTL;
              DS_CACHE: begin r_ok = 1'b1; r_pa = ea_q; end
              default: begin
                if (acc_permitted({1'b0, s_key, 1'b1}, acc_q)) begin
                  r_ok = 1'b1; r_pa = ea_q; r_prot = {1'b0, s_key, 1'b1};
                end else begin
                  r_cause = FC_PROT;
                end
              end
            endcase
          end
        end else if (is_fetch && s_nx) begin
          fin = 1'b1; r_cause = FC_NOEXEC;
        end
      end
      ST_WALK: if (pt_done) begin
        fin = 1'b1;
        if (!pt_hit) r_cause = FC_MISS;
        else if (acc_permitted(pg_prot, acc_q)) begin
          r_ok = 1'b1; r_pa = {pt_rpn, ea_q[PG_BITS-1:0]}; r_prot = pg_prot;
        end else begin
          r_cause = FC_PROT;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ea_q     <= '0;
      acc_q    <= '0;
      user_q   <= 1'b0;
      real_q   <= 1'b0;
      cls_q    <= '0;
      bm_start <= 1'b0;
      pt_start <= 1'b0;
      pt_vsid  <= '0;
      pt_pidx  <= '0;
      done     <= 1'b0;
      ok       <= 1'b0;
      pa       <= '0;
      prot     <= '0;
      exc      <= '0;
      err_code <= '0;
      dar      <= '0;
      dsisr    <= '0;
    end else begin
      done     <= 1'b0;
      bm_start <= 1'b0;
      pt_start <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          ea_q   <= req_ea;
          acc_q  <= req_acc;
          user_q <= req_user;
          real_q <= req_real;
          cls_q  <= req_dscls;
          state  <= ST_ROUTE;
        end
        ST_ROUTE: if (!real_q) begin
          bm_start <= 1'b1;
          state    <= ST_BLK;
        end
        ST_BLK: if (bm_done && !bm_hit) state <= ST_SEG;
        ST_SEG: if (!fin) begin
          pt_start <= 1'b1;
          pt_vsid  <= s_vsid;
          pt_pidx  <= ea_q[PG_BITS +: PIDX_W];
          state    <= ST_WALK;
        end
        default: ;
      endcase
      if (fin) begin
        state    <= ST_IDLE;
        done     <= 1'b1;
        ok       <= r_ok;
        pa       <= r_pa;
        prot     <= r_prot;
        exc      <= e_exc;
        err_code <= e_err;
        if (e_dar_we)   dar   <= ea_q;
        if (e_dstat_we) dsisr <= e_dstat;
      end
    end
  end
endmodule

// File: rtl/xs_chk.sv
module xs_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            done,
  input logic            ok,
  input logic [1:0]      exc,
  input logic [XLEN-1:0] dar,
  input logic [XLEN-1:0] dsisr,
  input logic [XLEN-1:0] ea_q,
  input logic            bm_start,
  input logic            pt_start,
  input logic            req_ready
);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst) (bm_start || pt_start) |=> !(bm_start || pt_start));
  // R1
  busy_starts_chk: assert property (@(posedge clk) disable iff (rst) (bm_start || pt_start) |-> !req_ready);
  // R13
  ok_noexc_chk: assert property (@(posedge clk) disable iff (rst) (done && ok) |-> (exc == 2'd0));
  // R13
  fault_exc_chk: assert property (@(posedge clk) disable iff (rst) (done && !ok) |-> (exc != 2'd0));
  // R13
  dar_capture_chk: assert property (@(posedge clk) disable iff (rst) (done && exc == 2'd2) |-> (dar == ea_q));
  // R13
  inst_keeps_chk: assert property (@(posedge clk) disable iff (rst) $rose(done) && exc == 2'd1 |-> ($stable(dar) && $stable(dsisr)));
endmodule

bind xlate_seq xs_chk #(.XLEN(XLEN)) i_xs_chk (
  .clk(clk), .rst(rst), .done(done), .ok(ok), .exc(exc), .dar(dar),
  .dsisr(dsisr), .ea_q(ea_q), .bm_start(bm_start), .pt_start(pt_start),
  .req_ready(req_ready)
);

// File: tb/test_xlate_seq.sv
module test_xlate_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_ready, req_user = 0, req_real = 0;
  logic [31:0] req_ea = 0;
  logic [1:0]  req_acc = 0;
  logic [2:0]  req_dscls = 0;
  logic [511:0] seg_regs;
  logic [31:0] sr_b [16];
  logic        bm_start, bm_fetch, bm_user, bm_done = 0, bm_hit = 0;
  logic [31:0] bm_ea, bm_pa = 0;
  logic [2:0]  bm_prot = 0;
  logic        pt_start, pt_done = 0, pt_hit = 0;
  logic [27:0] pt_vsid;
  logic [15:0] pt_pidx;
  logic [1:0]  pt_pp = 0;
  logic [19:0] pt_rpn = 0;
  logic        done, ok;
  logic [31:0] pa, err_code, dar, dsisr;
  logic [2:0]  prot;
  logic [1:0]  exc;

  always_comb for (int i = 0; i < 16; i++) seg_regs[i*32 +: 32] = sr_b[i];

  xlate_seq i_xlate_seq (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_dar = 0, m_dsisr = 0;

  task automatic chk(input logic cond, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic allowed(input logic [2:0] p, input logic [1:0] a);
    if (a == 2'd0) return p[2];
    if (a == 2'd2) return p[1];
    return p[0];
  endfunction

  // one request with modelled matcher and walker
  task automatic run_one(input logic [31:0] ea, input logic [1:0] acc, input logic usr, input logic rl,
                         input logic [2:0] cls, input logic bh, input logic [31:0] bpa, input logic [2:0] bpr,
                         input logic ph, input logic [1:0] pp, input logic [19:0] rpn, input logic poke);
    logic [31:0] sr; logic key;
    logic x_ok; logic [31:0] x_pa; logic [2:0] x_pr; logic [1:0] x_exc;
    logic [31:0] x_err, x_ds; logic x_dw, x_sw; int x_nb, x_np;
    int nb = 0, np = 0, nd = 0; int bc = -1, pc = -1;
    logic g_ok; logic [31:0] g_pa; logic [2:0] g_pr; logic [1:0] g_exc; logic [31:0] g_err;
    logic [2:0] pgp; int cause; // 0 ok,1 noexec,2 miss,3 prot,4 align,5 resv,6 ext
    sr = sr_b[ea[31:28]];
    key = usr ? sr[29] : sr[30];
    x_ok = 0; x_pa = 0; x_pr = 0; cause = 0; x_nb = 0; x_np = 0;
    if (rl) begin x_ok = 1; x_pa = ea; x_pr = 3'b111; end
    else begin
      x_nb = 1;
      if (bh) begin
        if (allowed(bpr, acc)) begin x_ok = 1; x_pa = bpa; x_pr = bpr; end else cause = 3;
      end else if (sr[31]) begin
        if (acc == 2'd0) cause = 1;
        else if (cls == 3'd1) cause = 4;
        else if (cls == 3'd2) cause = 5;
        else if (cls == 3'd4) cause = 6;
        else if (cls == 3'd3) begin x_ok = 1; x_pa = ea; end
        else if (allowed({1'b0, key, 1'b1}, acc)) begin x_ok = 1; x_pa = ea; x_pr = {1'b0, key, 1'b1}; end
        else cause = 3;
      end else if (acc == 2'd0 && sr[28]) cause = 1;
      else begin
        x_np = 1;
        if (!key) pgp = (pp == 2'd3) ? 3'b001 : 3'b011;
        else pgp = (pp == 2'd0) ? 3'b000 : (pp == 2'd2) ? 3'b011 : 3'b001;
        pgp[2] = pgp[0] & ~sr[28];
        if (!ph) cause = 2;
        else if (allowed(pgp, acc)) begin x_ok = 1; x_pa = {rpn, ea[11:0]}; x_pr = pgp; end
        else cause = 3;
      end
    end
    x_exc = 0; x_err = 0; x_ds = m_dsisr; x_dw = 0; x_sw = 0;
    if (cause == 1) begin x_exc = 1; x_err = 32'h1000_0000; end
    else if (cause == 4) begin x_exc = 3; x_dw = 1; end
    else if (cause != 0 && acc == 2'd0) begin x_exc = 1; x_err = (cause == 2) ? 32'h4000_0000 : 32'h0800_0000; end
    else if (cause != 0) begin
      x_exc = 2; x_dw = 1; x_sw = 1;
      case (cause)
        2: x_ds = (acc == 2'd2) ? 32'h4200_0000 : 32'h4000_0000;
        3: x_ds = (acc == 2'd2) ? 32'h0A00_0000 : 32'h0800_0000;
        5: x_ds = (acc == 2'd2) ? 32'h0600_0000 : 32'h0400_0000;
        default: x_ds = (acc == 2'd2) ? 32'h0610_0000 : 32'h0410_0000;
      endcase
    end
    if (x_dw) m_dar = ea;
    if (x_sw) m_dsisr = x_ds;

    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1; req_ea = ea; req_acc = acc; req_user = usr; req_real = rl; req_dscls = cls;
    @(negedge clk);
    req_valid = 0;
    for (int c = 0; c < 40; c++) begin
      bm_done = 0; pt_done = 0;
      if (poke && c == 1) begin req_valid = 1; req_ea = ~ea; req_real = ~rl; end
      if (poke && c == 2) req_valid = 0;
      if (bm_start) begin
        nb++; bc = int'($urandom % 3);
        chk(bm_ea == ea && bm_fetch == (acc == 2'd0) && bm_user == usr, "R3 matcher inputs", bm_ea, ea);
      end
      if (bc == 0) begin bm_done = 1; bm_hit = bh; bm_pa = bpa; bm_prot = bpr; bc = -1; end
      else if (bc > 0) bc--;
      if (pt_start) begin
        np++; pc = int'($urandom % 3);
        chk(pt_vsid == sr[27:0] && pt_pidx == ea[27:12], "R4 walk vsid/pidx", {4'd0, pt_vsid}, {4'd0, sr[27:0]});
      end
      if (pc == 0) begin pt_done = 1; pt_hit = ph; pt_pp = pp; pt_rpn = rpn; pc = -1; end
      else if (pc > 0) pc--;
      @(negedge clk);
      if (done) begin nd++; g_ok = ok; g_pa = pa; g_pr = prot; g_exc = exc; g_err = err_code; end
    end
    bm_done = 0; pt_done = 0;
    chk(nd == 1, "R1 single done pulse", nd, 1);
    chk(nb == x_nb, "R2/R3 matcher start count", nb, x_nb);
    chk(np == x_np, "R5 walk start count", np, x_np);
    if (nd == 1) begin
      chk(g_ok == x_ok, "R3/R7 ok", {31'd0, g_ok}, {31'd0, x_ok});
      chk(g_pa == x_pa, "R7/R12 pa", g_pa, x_pa);
      chk(g_pr == x_pr, "R7/R9 prot", {29'd0, g_pr}, {29'd0, x_pr});
      chk(g_exc == x_exc, "R5/R6/R8 exc", {30'd0, g_exc}, {30'd0, x_exc});
      chk(g_err == x_err, "R5/R6/R8 err_code", g_err, x_err);
    end
    chk(dar == m_dar, "R13 dar", dar, m_dar);
    chk(dsisr == m_dsisr, "R6/R11 dsisr", dsisr, m_dsisr);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) sr_b[i] = 32'h0000_1000 * i + 32'h0012_3450;
    sr_b[1] = 32'hC000_0111;       // direct-store, supervisor key 1
    sr_b[2] = 32'h1000_0222;       // no-execute
    sr_b[3] = 32'h200A_BCDE;       // user key 1, supervisor key 0
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(done == 0 && req_ready == 1, "R1 reset idle", {31'd0, done}, 32'd0);
    chk(dar == 0 && dsisr == 0, "R13 reset registers", dar | dsisr, 32'd0);

    // directed corners
    run_one(32'h3456_789A, 2'd2, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);                 // R2 real mode
    run_one(32'h3000_0010, 2'd1, 0, 0, 0, 1, 32'h8000_0010, 3'b001, 0, 0, 0, 0); // R3 block hit
    run_one(32'h3000_0020, 2'd2, 0, 0, 0, 1, 32'h8000_0020, 3'b001, 1, 2, 5, 0); // R3 block forbids store -> R8
    run_one(32'h3000_0024, 2'd0, 0, 0, 0, 1, 32'h8000_0024, 3'b011, 1, 2, 5, 0); // R3 block forbids fetch
    run_one(32'h1000_0040, 2'd0, 0, 0, 3, 0, 0, 0, 1, 0, 1, 0);                 // R5 ds fetch
    run_one(32'h2000_0040, 2'd0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0);                 // R5 noexec fetch
    run_one(32'h2000_0044, 2'd1, 0, 0, 0, 0, 0, 0, 1, 0, 7, 0);                 // R7 noexec load walks
    run_one(32'h3000_1000, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);                 // R6 fetch miss
    run_one(32'h3000_2000, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);                 // R6 load miss
    run_one(32'h3000_3000, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);                 // R6 store miss
    run_one(32'h3000_4000, 2'd2, 1, 0, 0, 0, 0, 0, 1, 1, 20'hABCDE, 0);         // R8 user key1 pp1 store
    run_one(32'h3000_5000, 2'd1, 1, 0, 0, 0, 0, 0, 1, 0, 20'h12345, 0);         // R8 user key1 pp0 load
    run_one(32'h3000_6000, 2'd0, 1, 0, 0, 0, 0, 0, 1, 0, 20'h12345, 0);         // R8 fetch pp0 key1
    run_one(32'h3000_7123, 2'd2, 0, 0, 0, 0, 0, 0, 1, 2, 20'h5A5A5, 0);         // R7 sup store ok
    run_one(32'h1000_0100, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);                 // R9 ds int key1 store
    run_one(32'h1000_0104, 2'd2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);                 // R9 ds int key0 store
    run_one(32'h1000_0108, 2'd1, 1, 0, 6, 0, 0, 0, 0, 0, 0, 0);                 // R9 class 6 as int
    run_one(32'h1000_0200, 2'd1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);                 // R10 float
    run_one(32'h1000_0300, 2'd1, 0, 0, 2, 0, 0, 0, 0, 0, 0, 0);                 // R11 resv load
    run_one(32'h1000_0304, 2'd2, 0, 0, 2, 0, 0, 0, 0, 0, 0, 0);                 // R11 resv store
    run_one(32'h1000_0400, 2'd1, 0, 0, 4, 0, 0, 0, 0, 0, 0, 0);                 // R11 ext load
    run_one(32'h1000_0404, 2'd2, 0, 0, 4, 0, 0, 0, 0, 0, 0, 0);                 // R11 ext store
    run_one(32'h1000_0500, 2'd2, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0);                 // R12 cache
    run_one(32'h3000_8000, 2'd1, 0, 0, 0, 0, 0, 0, 1, 3, 20'h00077, 1);         // R1 poke while busy
    run_one(32'h2000_0050, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);                 // R13 inst fault keeps dar

    // constrained random
    for (int t = 0; t < 300; t++) begin
      logic [31:0] ea; logic [2:0] cl;
      ea = $urandom;
      cl = 3'($urandom % 6);
      run_one(ea, 2'($urandom), 1'($urandom), ($urandom % 8) == 0, cl,
              ($urandom % 4) == 0, $urandom, 3'($urandom), ($urandom % 3) != 0,
              2'($urandom), 20'($urandom), 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule